// File: doc/BRIEF.md
# Self-Test Session Sequencer with Signature Check

This block runs one built-in self-test session for a circuit under test (CUT). Both the pattern generator and the CUT are outside the block. The block owns the input multiplexer in front of the CUT. In test mode the multiplexer passes the generator's patterns. In normal mode it passes the functional inputs.

When a session is started in test mode, the block captures three values: the seed, the pattern count and the expected signature. It then hands the seed to the generator with a one-cycle load strobe. Next it clears a multiple-input signature register (MISR) and folds the CUT response into that register once per pattern. When the programmed number of patterns is done, it compares the compacted signature with the expected one.

A mismatch means the CUT has a stuck-at-0 or stuck-at-1 fault, or some other fault visible at its outputs. On a mismatch the block flags failure and raises an interrupt. The interrupt stays set until software clears it. A one-cycle done strobe marks the end of every session. The pass or fail verdict is held until the next session starts.

Top module: `bist_session_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no start, the outputs `seed_load_o`, `tpg_en_o`, `done_o`, `pass_o`, `fail_o` and `irq_o` are all 0.
- R2: `cut_in_o` equals `tpg_pat_i` when `test_mode_i` is 1, and equals `func_in_i` when it is 0. This path is combinational.
- R3: A start is accepted only when the block is idle, `start_i` is 1 and `test_mode_i` is 1. A start pulse in normal mode produces no load strobe, no pattern enable and no done strobe. Seed, count and expected signature are captured at the accepting clock edge.
- R4: In the cycle after an accepted start, `seed_load_o` is 1 for exactly one cycle and `seed_o` shows the captured seed.
- R5: After the load cycle, `tpg_en_o` is 1 for exactly as many test-mode cycles as the captured pattern count. A count of 0 gives no enabled cycle.
- R6: The signature is cleared to 0 in the load cycle. In every enabled cycle it becomes S' = ((S << 1) mod 256) XOR (8'h1D if bit 7 of S is 1, else 0) XOR `cut_rsp_i`, for the default 8-bit width and polynomial.
- R7: While `test_mode_i` is 0 during a session, `tpg_en_o` is 0, and the signature and the remaining count are held. The session resumes when test mode returns.
- R8: `done_o` pulses for one cycle two cycles after the last enabled cycle. `pass_o` (signature equals expected) or `fail_o` (it differs) is valid from that cycle on. Both hold until the next accepted start, which clears them.
- R9: A failing comparison sets `irq_o`. `irq_o` stays set through later cycles and later sessions until `irq_clr_i` is 1 at a clock edge.
- R10: If `irq_clr_i` is 1 on the same edge at which a failing comparison is recorded, `irq_o` is set.
- R11: A start pulse during a running session is ignored. It causes no second load strobe and does not change the pattern count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Session start request |
| test_mode_i | input | 1 | 1 = test mode, 0 = normal mode |
| seed_i | input | PAT_W | Seed for the pattern generator |
| pat_count_i | input | CNT_W | Number of patterns to apply |
| exp_sig_i | input | RSP_W | Expected final signature |
| func_in_i | input | PAT_W | Functional inputs for the CUT |
| tpg_pat_i | input | PAT_W | Pattern from the external generator |
| cut_in_o | output | PAT_W | Multiplexed CUT inputs |
| seed_load_o | output | 1 | One-cycle seed load strobe to the generator |
| seed_o | output | PAT_W | Captured seed value |
| tpg_en_o | output | 1 | Advance the generator; the response is sampled this cycle |
| cut_rsp_i | input | RSP_W | CUT output bus |
| done_o | output | 1 | One-cycle end-of-session strobe |
| pass_o | output | 1 | Signature matched |
| fail_o | output | 1 | Signature mismatched |
| irq_o | output | 1 | Sticky error interrupt |
| irq_clr_i | input | 1 | Interrupt clear |

## Verification
The bench compares cycle counts and signatures against models built from R5 and R6 alone.

Several corner cases are targeted, each with the failure a wrong design would show:
- A zero pattern count. An off-by-one counter would run 65536 or 1 patterns.
- A mode drop in the middle of a run. A design that keeps compacting or counting would fold junk into the signature.
- A second start during a run. A design that reloads would re-strobe the seed and restart the count.
- A clear that coincides with a failing compare. A design that gives priority to the clear would lose the interrupt.

The bench also checks that the verdict outputs hold and are cleared at the right time. It forces a response bit to 1 to model a stuck-at fault and confirms that this is flagged.

// File: rtl/bist_pkg.sv
`timescale 1ns/1ps
package bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_RUN  = 3'd2,
    ST_CMP  = 3'd3,
    ST_DONE = 3'd4
  } bist_state_e;
endpackage

// File: rtl/bist_rst_sync.sv
`timescale 1ns/1ps
module bist_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/bist_cut_mux.sv
`timescale 1ns/1ps
module bist_cut_mux #(
  parameter int W = 8
) (
  input  logic         test_mode_i,
  input  logic [W-1:0] func_i,
  input  logic [W-1:0] pat_i,
  output logic [W-1:0] cut_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign cut_o[b] = test_mode_i ? pat_i[b] : func_i[b];
  end

  always_comb begin
    AST_MUX_SELECT: assert (cut_o == (test_mode_i ? pat_i : func_i) || $isunknown({test_mode_i, func_i, pat_i})); // R2
  end
endmodule

// File: rtl/bist_seq_fsm.sv
`timescale 1ns/1ps
module bist_seq_fsm
  import bist_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             test_mode_i,
  input  logic [CNT_W-1:0] pat_count_i,
  output bist_state_e      state_o,
  output logic             accept_o,
  output logic             misr_clr_o,
  output logic             misr_en_o,
  output logic             cmp_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  bist_state_e      state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             remain_en;

  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    remain_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && test_mode_i) begin
          state_d   = ST_LOAD;
          remain_d  = pat_count_i;
          remain_en = 1'b1;
        end
      end
      ST_LOAD: state_d = (remain_q == '0) ? ST_CMP : ST_RUN;
      ST_RUN: begin
        if (test_mode_i) begin
          remain_d  = remain_q - CNT_ONE;
          remain_en = 1'b1;
          if (remain_q == CNT_ONE) state_d = ST_CMP;
        end
      end
      ST_CMP:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end

  assign state_o    = state_q;
  assign accept_o   = (state_q == ST_IDLE) && start_i && test_mode_i;
  assign misr_clr_o = (state_q == ST_LOAD);
  assign misr_en_o  = (state_q == ST_RUN) && test_mode_i;
  assign cmp_o      = (state_q == ST_CMP);
  assign done_o     = (state_q == ST_DONE);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (remain_q != '0)); // R5
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !test_mode_i) |=> (state_q == ST_RUN && $stable(remain_q))); // R7
  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |=> (state_q != ST_LOAD)); // R4
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> (state_q != ST_LOAD)); // R11
endmodule

// File: rtl/bist_misr.sv
`timescale 1ns/1ps
module bist_misr #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] sig_q, sig_d, shifted;

  always_comb begin
    shifted[0] = 1'b0;
    for (int b = 1; b < W; b++) shifted[b] = sig_q[b-1];
    for (int b = 0; b < W; b++) shifted[b] = shifted[b] ^ (POLY[b] & sig_q[W-1]);
  end

  always_comb begin
    sig_d = sig_q;
    if (clr_i)     sig_d = '0;
    else if (en_i) sig_d = shifted ^ data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sig_q <= '0;
    else if (clr_i || en_i)  sig_q <= sig_d;
  end

  assign sig_o = sig_q;

  AST_MISR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sig_o == '0)); // R6
  AST_MISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(sig_o)); // R7
endmodule

// File: rtl/bist_result.sv
`timescale 1ns/1ps
module bist_result #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic         cmp_i,
  input  logic [W-1:0] sig_i,
  input  logic [W-1:0] exp_i,
  input  logic         irq_clr_i,
  output logic         pass_o,
  output logic         fail_o,
  output logic         irq_o
);
  logic match;
  logic pass_q, pass_d, fail_q, fail_d, irq_q, irq_d;

  assign match = (sig_i == exp_i);

  always_comb begin
    pass_d = pass_q;
    fail_d = fail_q;
    if (accept_i) begin
      pass_d = 1'b0;
      fail_d = 1'b0;
    end else if (cmp_i) begin
      pass_d = match;
      fail_d = !match;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (cmp_i && !match) irq_d = 1'b1;
    else if (irq_clr_i)  irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pass_q <= pass_d;
      fail_q <= fail_d;
      irq_q  <= irq_d;
    end
  end

  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign irq_o  = irq_q;

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o); // R9
  AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_i && (sig_i != exp_i) && irq_clr_i) |=> irq_o); // R10
  AST_FAIL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_i && (sig_i != exp_i)) |=> (fail_o && irq_o)); // R9
endmodule

// File: rtl/bist_session_ctrl.sv
`timescale 1ns/1ps
module bist_session_ctrl
  import bist_pkg::*;
#(
  parameter int               PAT_W = 8,
  parameter int               RSP_W = 8,
  parameter int               CNT_W = 16,
  parameter logic [RSP_W-1:0] POLY  = 8'h1D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             test_mode_i,
  input  logic [PAT_W-1:0] seed_i,
  input  logic [CNT_W-1:0] pat_count_i,
  input  logic [RSP_W-1:0] exp_sig_i,
  input  logic [PAT_W-1:0] func_in_i,
  input  logic [PAT_W-1:0] tpg_pat_i,
  output logic [PAT_W-1:0] cut_in_o,
  output logic             seed_load_o,
  output logic [PAT_W-1:0] seed_o,
  output logic             tpg_en_o,
  input  logic [RSP_W-1:0] cut_rsp_i,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             irq_o,
  input  logic             irq_clr_i
);
  logic             rst_n_s;
  bist_state_e      state;
  logic             accept, misr_clr, misr_en, cmp;
  logic [RSP_W-1:0] sig;
  logic [PAT_W-1:0] seed_q;
  logic [RSP_W-1:0] exp_q;

  bist_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync_o(rst_n_s)
  );

  bist_cut_mux #(.W(PAT_W)) u_mux (
    .test_mode_i(test_mode_i), .func_i(func_in_i), .pat_i(tpg_pat_i), .cut_o(cut_in_o)
  );

  bist_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .test_mode_i(test_mode_i),
    .pat_count_i(pat_count_i), .state_o(state), .accept_o(accept),
    .misr_clr_o(misr_clr), .misr_en_o(misr_en), .cmp_o(cmp), .done_o(done_o)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      seed_q <= '0;
      exp_q  <= '0;
    end else if (accept) begin
      seed_q <= seed_i;
      exp_q  <= exp_sig_i;
    end
  end

  bist_misr #(.W(RSP_W), .POLY(POLY)) u_misr (
    .clk(clk), .rst_n(rst_n_s), .clr_i(misr_clr), .en_i(misr_en),
    .data_i(cut_rsp_i), .sig_o(sig)
  );

  bist_result #(.W(RSP_W)) u_res (
    .clk(clk), .rst_n(rst_n_s), .accept_i(accept), .cmp_i(cmp),
    .sig_i(sig), .exp_i(exp_q), .irq_clr_i(irq_clr_i),
    .pass_o(pass_o), .fail_o(fail_o), .irq_o(irq_o)
  );

  assign seed_load_o = misr_clr;
  assign seed_o      = seed_q;
  assign tpg_en_o    = misr_en;

  AST_SEED_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    seed_load_o |=> !seed_load_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o); // R8
  AST_EN_NEEDS_TEST: assert property (@(posedge clk) disable iff (!rst_n_s)
    tpg_en_o |-> test_mode_i); // R7
  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |=> (seed_load_o && seed_o == $past(seed_i))); // R3
endmodule

// File: tb/bist_session_ctrl_tb_top.sv
`timescale 1ns/1ps
module bist_session_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, test_mode_i, irq_clr_i;
  logic [7:0]  seed_i, exp_sig_i, func_in_i, tpg_pat_i, cut_rsp_i;
  logic [15:0] pat_count_i;
  logic [7:0]  cut_in_o, seed_o;
  logic        seed_load_o, tpg_en_o, done_o, pass_o, fail_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit irq_model = 1'b0;

  always #2 clk = ~clk;

  bist_session_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_mode_i(test_mode_i),
    .seed_i(seed_i), .pat_count_i(pat_count_i), .exp_sig_i(exp_sig_i),
    .func_in_i(func_in_i), .tpg_pat_i(tpg_pat_i), .cut_in_o(cut_in_o),
    .seed_load_o(seed_load_o), .seed_o(seed_o), .tpg_en_o(tpg_en_o),
    .cut_rsp_i(cut_rsp_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .irq_o(irq_o), .irq_clr_i(irq_clr_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rsp_of(input logic [7:0] seed, input int k, input logic [7:0] m);
    return ((seed ^ 8'(k * 29)) + 8'(k)) | m;
  endfunction

  function automatic logic [7:0] sig_of(input logic [7:0] seed, input int n, input logic [7:0] m);
    logic [7:0] s = 8'h00;
    for (int k = 0; k < n; k++)
      s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00) ^ rsp_of(seed, k, m);
    return s;
  endfunction

  task automatic run_session(input logic [7:0] seed, input int n, input bit bad_exp,
                             input logic [7:0] stuck, input int pause_at,
                             input bit clr_hold, input bit restart);
    logic [7:0] exp_sig;
    bit         want_pass, paused_done, restarted;
    int         k, en_cnt, extra_loads, pause_left, guard;
    exp_sig    = sig_of(seed, n, 8'h00) ^ (bad_exp ? 8'h01 : 8'h00);
    want_pass  = (sig_of(seed, n, stuck) == exp_sig);
    k = 0; en_cnt = 0; extra_loads = 0; pause_left = 3; guard = 0;
    paused_done = 1'b0; restarted = 1'b0;
    @(negedge clk);
    seed_i = seed; pat_count_i = 16'(n); exp_sig_i = exp_sig;
    test_mode_i = 1'b1; start_i = 1'b1; irq_clr_i = clr_hold;
    @(negedge clk);
    start_i = 1'b0; seed_i = ~seed; exp_sig_i = ~exp_sig; pat_count_i = 16'hFFFF;
    #1;
    chk(seed_load_o == 1'b1, "R4", "seed load strobe", 32'(seed_load_o), 1);
    chk(seed_o == seed, "R4", "seed value", 32'(seed_o), 32'(seed));
    chk(!pass_o && !fail_o, "R8", "verdict cleared at start", {pass_o, fail_o}, 0);
    forever begin
      @(negedge clk);
      start_i = 1'b0;
      if (restart && !restarted && k == 1) begin
        start_i = 1'b1; seed_i = 8'h3C; pat_count_i = 16'd2; restarted = 1'b1;
      end
      if (pause_at >= 0 && !paused_done && k == pause_at && k < n) begin
        test_mode_i = 1'b0; pause_left--;
        if (pause_left == 0) paused_done = 1'b1;
      end else begin
        test_mode_i = 1'b1;
      end
      #1;
      if (seed_load_o) extra_loads++;
      if (!test_mode_i) begin
        chk(!tpg_en_o, "R7", "enable low in normal mode", 32'(tpg_en_o), 0);
        cut_rsp_i = 8'hA5;
      end
      if (tpg_en_o) begin
        cut_rsp_i = rsp_of(seed, k, stuck);
        k++; en_cnt++;
      end
      if (done_o) break;
      guard++;
      if (guard > 2000) begin
        chk(1'b0, "R5", "session never finished", 32'(guard), 0);
        break;
      end
    end
    test_mode_i = 1'b1;
    irq_model = !want_pass ? 1'b1 : (clr_hold ? 1'b0 : irq_model);
    chk(en_cnt == n, "R5", "enabled cycle count", 32'(en_cnt), 32'(n));
    chk(pass_o == want_pass && fail_o == !want_pass, "R6", "verdict",
        {pass_o, fail_o}, {want_pass, !want_pass});
    chk(irq_o == irq_model, clr_hold ? "R10" : "R9", "irq at done", 32'(irq_o), 32'(irq_model));
    if (restart)
      chk(extra_loads == 0, "R11", "second load strobe", 32'(extra_loads), 0);
    irq_clr_i = 1'b0;
    @(negedge clk); #1;
    chk(!done_o, "R8", "done is one cycle", 32'(done_o), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(pass_o == want_pass && fail_o == !want_pass, "R8", "verdict held",
        {pass_o, fail_o}, {want_pass, !want_pass});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 0; test_mode_i = 0; irq_clr_i = 0;
    seed_i = 0; pat_count_i = 0; exp_sig_i = 0; func_in_i = 0; tpg_pat_i = 0; cut_rsp_i = 0;
    repeat (3) @(negedge clk);
    #1;
    chk({seed_load_o, tpg_en_o, done_o, pass_o, fail_o, irq_o} == 6'b0, "R1",
        "outputs in reset", {seed_load_o, tpg_en_o, done_o, pass_o, fail_o, irq_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk({seed_load_o, tpg_en_o, done_o, pass_o, fail_o, irq_o} == 6'b0, "R1",
        "outputs after reset", {seed_load_o, tpg_en_o, done_o, pass_o, fail_o, irq_o}, 0);
  endtask

  task automatic t_mux();
    @(negedge clk);
    tpg_pat_i = 8'h5A; func_in_i = 8'hC3; test_mode_i = 1'b1;
    #1 chk(cut_in_o == 8'h5A, "R2", "test mode path", 32'(cut_in_o), 32'h5A);
    test_mode_i = 1'b0;
    #1 chk(cut_in_o == 8'hC3, "R2", "normal mode path", 32'(cut_in_o), 32'hC3);
  endtask

  task automatic t_start_in_normal();
    int seen = 0;
    @(negedge clk);
    test_mode_i = 1'b0; start_i = 1'b1; seed_i = 8'h77; pat_count_i = 16'd4;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) begin
      #1 if (seed_load_o || tpg_en_o || done_o) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R3", "start ignored in normal mode", 32'(seen), 0);
  endtask

  task automatic t_irq_clear();
    repeat (5) @(negedge clk);
    #1 chk(irq_o == 1'b1, "R9", "irq sticky while idle", 32'(irq_o), 1);
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0; irq_model = 1'b0;
    #1 chk(irq_o == 1'b0, "R9", "irq cleared", 32'(irq_o), 0);
  endtask

  initial begin
    t_reset();
    t_mux();
    t_start_in_normal();
    run_session(8'h4B, 5, 0, 8'h00, -1, 0, 0);    // R5 R6 good run
    run_session(8'h91, 6, 0, 8'h08, -1, 0, 0);    // R6 R9 stuck-at-1 on bit 3
    run_session(8'h20, 4, 0, 8'h00, -1, 0, 0);    // R9 irq survives a passing session
    t_irq_clear();
    run_session(8'h10, 0, 0, 8'h00, -1, 0, 0);    // R5 zero count passes with zero expected
    run_session(8'h10, 0, 1, 8'h00, -1, 0, 0);    // R5 zero count, wrong expected
    run_session(8'hE7, 5, 1, 8'h00, -1, 1, 0);    // R10 clear held during failing compare
    t_irq_clear();
    run_session(8'h33, 8, 0, 8'h00, 3, 0, 0);     // R7 pause mid run
    run_session(8'h6D, 7, 0, 8'h00, -1, 0, 1);    // R11 start during run
    run_session(8'hA2, 200, 0, 8'h00, -1, 0, 0);  // R5 long run
    run_session(8'h0F, 9, 0, 8'h01, -1, 0, 0);    // R6 stuck-at-1 on bit 0
    run_session(8'h55, 3, 0, 8'h00, -1, 1, 0);    // R9 clear held through passing session
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule